// File: doc/BRIEF.md
# Register-Controlled Baud Clock Prescaler

This block divides the machine clock down to a baud-rate enable for a serial port. Software programs it through a single 8-bit read/write control word. The word has a run/stop bit and a 4-bit division code. The code is inverted: the divide ratio is sixteen minus the code, so the legal codes cover divide by 2 through divide by 8. While the block is running on a legal code, it emits a one-clock enable pulse once every N machine clocks.

The all-ones reset code and every code with its top bit clear are disabled settings. A disabled setting raises a flag and produces no pulses, even with the run bit set. Any write to the control word clears the divider, so the first pulse after a write comes exactly N clocks later. A ready flag rises only once two full divided periods have elapsed at the new setting. Downstream logic can wait for it before starting a transfer.

The sequencing is a four-state machine:
- `ST_STOP`: idle. The block is halted or holds a disabled code.
- `ST_WAIT1`: the first settling period after a restart.
- `ST_WAIT2`: the second settling period.
- `ST_LOCKED`: ready.

Its transitions are:
- **go**: a write with run set and a legal code moves any state to `ST_WAIT1`.
- **halt**: a write with run clear or a disabled code moves any state to `ST_STOP`.
- **first-wrap**: `ST_WAIT1` moves to `ST_WAIT2` when a period completes.
- **second-wrap**: `ST_WAIT2` moves to `ST_LOCKED` when the next period completes.
- **hold**: `ST_LOCKED` stays until the next write.
- Synchronous reset returns the machine to `ST_STOP`.

Top module: `baud_prescaler`

## Requirements
- R1: After synchronous reset, `rd_data` reads 0x0F (run bit 0, code 4'b1111). `tick` and `ready` are 0 and `bad_code` is 1.
- R2: A write with `wr_en` loads bit 7 as the run bit and bits 3..0 as the code. From the next cycle `rd_data` returns {run, 3'b000, code}. Bits 6..4 of a write are ignored and always read 0.
- R3: A legal code c (bit 3 = 1 and c != 4'b1111) selects a divide ratio N = 16 − c, with 4'b1110 giving 2 and 4'b1000 giving 8. While running, consecutive pulses are exactly N clocks apart.
- R4: When the stored code is 4'b1111 or has bit 3 = 0, `bad_code` is 1 and `tick` stays 0, whatever the run bit is. For every legal code, `bad_code` is 0.
- R5: While the stored run bit is 0, `tick` stays 0.
- R6: `tick` is high for exactly one clock per period and is 0 in every other cycle of the period.
- R7: Any write clears the divider. When the write leaves the block running on a legal code, the first pulse appears in the cycle that begins N rising edges after the write edge. A pulse that would have fallen on the write edge is suppressed.
- R8: `ready` rises in the same cycle as the second pulse after a restart and stays high while no write occurs. Any write clears it at once. It is never high while the block is halted or holds a disabled code.
- R9: A reset asserted while the block is running returns it to the R1 state on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write value |
| rd_data | output | 8 | Control word readback |
| tick | output | 1 | One-clock baud enable pulse |
| bad_code | output | 1 | Stored code is a disabled setting |
| ready | output | 1 | Two full periods elapsed since restart |

## Verification
The bench targets four corner cases:
- **Writes on the wrap edge.** A design that let the old wrap through would emit a pulse one clock after the write. It would also report `ready` early.
- **The edges of the code range.** These are 4'b1110, 4'b1000, 4'b1111 and codes with bit 3 clear. A decoder that treated the top or bottom code as legal, or dropped the inversion, would emit pulses on a disabled code or space them 16 − N clocks off.
- **The ready timing.** An off-by-one period count would raise the flag with the first or the third pulse.
- **Stray upper write bits and a reset during operation.** A design that wrongly handled either would show nonzero unused readback bits or a pulse surviving the reset.

// File: rtl/baud_prescaler_pkg.sv
package baud_prescaler_pkg;
    typedef enum logic [1:0] {
        ST_STOP,
        ST_WAIT1,
        ST_WAIT2,
        ST_LOCKED
    } pre_state_t;
endpackage

// File: rtl/prescaler_ctrl_reg.sv
module prescaler_ctrl_reg #(
    parameter int REG_W  = 8,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic              run,
    output logic [CODE_W-1:0] code,
    output logic [REG_W-1:0]  rd_data
);
    localparam int PAD_W = REG_W - 1 - CODE_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            code <= '1;
        end else if (wr_en) begin
            run  <= wr_data[REG_W-1];
            code <= wr_data[CODE_W-1:0];
        end
    end

    assign rd_data = {run, {PAD_W{1'b0}}, code};

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[REG_W-1] == $past(wr_data[REG_W-1]))
               && (rd_data[CODE_W-1:0] == $past(wr_data[CODE_W-1:0]))); // R2
endmodule

// File: rtl/prescaler_decode.sv
module prescaler_decode #(
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic              legal,
    output logic [CODE_W-1:0] div
);
    // ratio = 2**CODE_W - code, taken modulo 2**CODE_W
    assign div   = ~code + CODE_W'(1);
    assign legal = code[CODE_W-1] && (code != '1);
endmodule

// File: rtl/prescaler_core.sv
module prescaler_core
    import baud_prescaler_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              start_ok,
    input  logic [CODE_W-1:0] div,
    output logic              tick,
    output logic              ready
);
    localparam int CNT_W = CODE_W - 1;

    pre_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             running;
    logic             wrap;

    assign running = (state != ST_STOP);
    assign wrap    = running && ({1'b0, cnt} == div - CODE_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_STOP;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STOP:   state_nx = ST_STOP;
            ST_WAIT1:  if (wrap) state_nx = ST_WAIT2;
            ST_WAIT2:  if (wrap) state_nx = ST_LOCKED;
            ST_LOCKED: state_nx = ST_LOCKED;
        endcase
        if (restart) state_nx = start_ok ? ST_WAIT1 : ST_STOP;
    end

    // divider counter
    always_ff @(posedge clk) begin
        if (rst || restart || !running || wrap) cnt <= '0;
        else                                    cnt <= cnt + CNT_W'(1);
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            tick  <= 1'b0;
            ready <= 1'b0;
        end else begin
            tick  <= wrap && !restart;
            ready <= (state_nx == ST_LOCKED);
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R6
    AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (rst)
        running |-> ({1'b0, cnt} < div)); // R3
    AST_READY_WITH_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> tick); // R8
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!tick && !ready)); // R7
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int REG_W  = 8,
    parameter int CODE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             tick,
    output logic             bad_code,
    output logic             ready
);
    localparam int PAD_W = REG_W - 1 - CODE_W;

    logic              run;
    logic [CODE_W-1:0] code;
    logic              cur_legal, new_legal;
    logic [CODE_W-1:0] cur_div, new_div;

    prescaler_ctrl_reg #(.REG_W(REG_W), .CODE_W(CODE_W)) u_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .run(run), .code(code), .rd_data(rd_data)
    );

    prescaler_decode #(.CODE_W(CODE_W)) u_dec_cur (
        .code(code), .legal(cur_legal), .div(cur_div)
    );

    prescaler_decode #(.CODE_W(CODE_W)) u_dec_new (
        .code(wr_data[CODE_W-1:0]), .legal(new_legal), .div(new_div)
    );

    prescaler_core #(.CODE_W(CODE_W)) u_core (
        .clk(clk), .rst(rst), .restart(wr_en),
        .start_ok(wr_data[REG_W-1] && new_legal),
        .div(cur_div), .tick(tick), .ready(ready)
    );

    assign bad_code = !cur_legal;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (rd_data == {1'b0, {PAD_W{1'b0}}, {CODE_W{1'b1}}}) && !tick && !ready && bad_code); // R1
    AST_BAD_SILENT: assert property (@(posedge clk) disable iff (rst)
        bad_code |-> !tick && !ready); // R4
    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (rst)
        !rd_data[REG_W-1] |-> !tick && !ready); // R5
    AST_NEW_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && new_legal) |-> (new_div >= CODE_W'(2))); // R3
endmodule

// File: tb/baud_prescaler_bench.sv
`timescale 1ns/1ps
module baud_prescaler_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tick, bad_code, ready;

    baud_prescaler u_baud_prescaler (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick(tick), .bad_code(bad_code), .ready(ready)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // reference model state
    bit       m_run = 0;
    bit [3:0] m_code = 4'hF;
    int       m_cnt = 0;
    bit       m_tick = 0;
    int       m_per = 0;
    bit       m_act = 0;
    bit       m_rst_seen = 0;
    bit       mid_run_rst = 0;
    int       cyc = 0;
    int       restart_cyc = 0;
    int       last_tick_cyc = -1;

    function automatic bit code_ok(input bit [3:0] c);
        return c[3] && (c != 4'hF);
    endfunction

    function automatic int div_of(input bit [3:0] c);
        return 16 - int'(c);
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, cyc, actual, expected);
        end
    endtask

    task automatic step();
        @(posedge clk);
        cyc++;
        m_rst_seen = rst;
        if (rst) begin
            m_run = 0; m_code = 4'hF; m_cnt = 0; m_tick = 0; m_per = 0; m_act = 0;
            last_tick_cyc = -1;
        end else if (wr_en) begin
            m_run = wr_data[7]; m_code = wr_data[3:0];
            m_cnt = 0; m_tick = 0; m_per = 0;
            m_act = m_run && code_ok(m_code);
            restart_cyc = cyc; last_tick_cyc = -1;
        end else if (m_act) begin
            if (m_cnt == div_of(m_code) - 1) begin
                m_cnt = 0; m_tick = 1;
                if (m_per < 2) m_per++;
            end else begin
                m_cnt++; m_tick = 0;
            end
        end else begin
            m_tick = 0;
        end
        @(negedge clk);
        if (m_rst_seen) begin
            if (mid_run_rst) begin
                check("R9 rd_data", int'(rd_data), 8'h0F);
                check("R9 tick", int'(tick), 0);
                check("R9 ready", int'(ready), 0);
            end else begin
                check("R1 rd_data", int'(rd_data), 8'h0F);
                check("R1 tick", int'(tick), 0);
                check("R1 ready", int'(ready), 0);
                check("R1 bad_code", int'(bad_code), 1);
            end
        end else begin
            check("R2 rd_data", int'(rd_data), int'({m_run, 3'b000, m_code}));
            check("R4 bad_code", int'(bad_code), int'(!code_ok(m_code)));
            if (!m_run)                check("R5 tick", int'(tick), int'(m_tick));
            else if (!code_ok(m_code)) check("R4 tick", int'(tick), int'(m_tick));
            else                       check("R6 tick", int'(tick), int'(m_tick));
            check("R8 ready", int'(ready), int'(m_act && m_per == 2));
            if (tick && m_act) begin
                if (last_tick_cyc < 0) check("R7 first pulse delay", cyc - restart_cyc, div_of(m_code));
                else                   check("R3 pulse spacing", cyc - last_tick_cyc, div_of(m_code));
                last_tick_cyc = cyc;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write(input bit [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5A17C3));
        // R1: reset state
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(3);
        // R3: range edges, stray upper bits for R2
        write(8'hFE); idle(20);   // divide by 2
        write(8'h88); idle(40);   // divide by 8
        write(8'h0B); idle(20);   // R5: stopped, legal code
        write(8'h8F); idle(20);   // R4: disabled all-ones code
        write(8'h85); idle(20);   // R4: bit 3 clear
        // R7: rewrite exactly on the wrap edge, divide by 4
        write(8'h8C); idle(3);
        write(8'h8C); idle(3);
        write(8'h8C); idle(20);
        // R9: reset while running
        write(8'h8D); idle(15);
        mid_run_rst = 1'b1; rst = 1'b1;
        idle(1);
        rst = 1'b0; mid_run_rst = 1'b0;
        idle(5);
        // random mix
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 39) == 0) begin
                bit [7:0] d;
                d[6:4] = 3'($urandom);
                d[7]   = ($urandom_range(0, 9) < 8);
                if ($urandom_range(0, 9) < 7) d[3:0] = 4'(8 + $urandom_range(0, 6));
                else                          d[3:0] = 4'($urandom);
                write(d);
            end else if ($urandom_range(0, 999) == 0) begin
                mid_run_rst = 1'b1; rst = 1'b1;
                idle(1);
                rst = 1'b0; mid_run_rst = 1'b0;
            end else begin
                idle(1);
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule